// File: doc/BRIEF.md
# Strobed Channel Preset Selector

This block keeps a table of frequency words, one per channel, plus a separate power-on default word. An external control path stores words into the table or into the default slot through a save port. A parallel channel index is chosen by an external active-low strobe. When the strobe falls, the index is captured and the word stored in that channel becomes the active frequency. A command parser can also load the active frequency directly. Whichever source acts last decides the active value, and the strobe wins if both act in the same cycle.

The strobe and the index arrive asynchronously. Both pass through two synchronizing flops, and the strobe's falling edge is detected in the system clock domain. A registered read port lets a listing formatter walk the table and the default slot. After reset the active frequency equals the default word. A one-cycle pulse marks every clock in which the active value actually changes.

Top module: `preset_selector`

## Requirements
- R1: After reset, active_freq equals the DEFAULT_WORD parameter, freq_changed is low, the default slot reads DEFAULT_WORD, and every table channel reads 0.
- R2: When save_en is high and save_dflt is low at a rising edge, save_data is stored in channel save_ch (bit 0 is the LSB, channels 0 to 63). Table writes never alter active_freq.
- R3: A high-to-low transition of sel_strobe_n loads active_freq with the word of channel sel_ch at the third rising clock edge after the transition, and not before.
- R4: Holding sel_strobe_n low, changing sel_ch while it is low, or raising sel_strobe_n leaves active_freq unchanged.
- R5: When save_dflt is high at a rising edge, save_data is stored in the default slot and save_ch is ignored. active_freq is not changed.
- R6: A cycle with direct_en high loads active_freq with direct_data at that rising edge.
- R7: If direct_en is high in the same cycle that a strobe fall is acted on, the table word is loaded and direct_data is discarded.
- R8: freq_changed is high for exactly the one cycle after a load that alters active_freq. A load of an identical value gives no pulse.
- R9: rd_data shows the default slot when rd_dflt is high, otherwise channel rd_ch, one rising edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_strobe_n | input | 1 | Asynchronous channel strobe, idle high |
| sel_ch | input | 6 | Asynchronous channel index |
| save_en | input | 1 | Store save_data into channel save_ch |
| save_dflt | input | 1 | Store save_data into the default slot |
| save_ch | input | 6 | Channel to store into |
| save_data | input | 32 | Word to store |
| direct_en | input | 1 | Load direct_data into the active frequency |
| direct_data | input | 32 | Direct frequency word from the parser |
| rd_dflt | input | 1 | Read the default slot instead of a channel |
| rd_ch | input | 6 | Channel to read |
| rd_data | output | 32 | Registered read word |
| active_freq | output | 32 | Active frequency word |
| freq_changed | output | 1 | One-cycle pulse when active_freq changes |

## Verification
The bench measures strobe latency at two edges and at three edges after the fall. A design with the wrong synchronizer depth updates too early or too late. A held-low strobe with a changing index, and a rising strobe, must leave the output alone. A design that triggers on a level or on the rising edge would reload. The bench also raises a direct load in exactly the cycle the fall is acted on, to catch a wrong priority. It reloads an identical word to catch a pulse that fires on every load instead of on every change. A default-slot save must not touch the channel table or the output.

// File: rtl/freq_sel_pkg.sv
package freq_sel_pkg;
  typedef enum logic [1:0] {SRC_NONE, SRC_STROBE, SRC_DIRECT} load_src_e;

  // strobe outranks a direct load in the same cycle
  function automatic load_src_e pick_src(input logic fall, input logic direct);
    if (fall) return SRC_STROBE;
    if (direct) return SRC_DIRECT;
    return SRC_NONE;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_n,
  input  logic [IDX_W-1:0] idx_in,
  output logic             fall,
  output logic [IDX_W-1:0] idx_out
);
  logic st_m, st_s, st_d;
  logic [IDX_W-1:0] ix_m, ix_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_m <= 1'b1;
      st_s <= 1'b1;
      st_d <= 1'b1;
      ix_m <= '0;
      ix_s <= '0;
    end else begin
      st_m <= strobe_n;
      st_s <= st_m;
      st_d <= st_s;
      ix_m <= idx_in;
      ix_s <= ix_m;
    end
  end

  assign fall    = st_d & ~st_s;
  assign idx_out = ix_s;

  assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/preset_table.sv
module preset_table #(
  parameter int unsigned IDX_W        = 6,
  parameter int unsigned FREQ_W       = 32,
  parameter logic [FREQ_W-1:0] DEFAULT_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_en,
  input  logic              save_dflt,
  input  logic [IDX_W-1:0]  save_ch,
  input  logic [FREQ_W-1:0] save_data,
  input  logic [IDX_W-1:0]  lk_ch,
  output logic [FREQ_W-1:0] lk_word,
  input  logic              rd_dflt,
  input  logic [IDX_W-1:0]  rd_ch,
  output logic [FREQ_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [FREQ_W-1:0] mem [DEPTH];
  logic [FREQ_W-1:0] dflt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      dflt_q <= DEFAULT_WORD;
    end else if (save_dflt) begin
      dflt_q <= save_data;
    end else if (save_en) begin
      mem[save_ch] <= save_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_dflt ? dflt_q : mem[rd_ch];
  end

  assign lk_word = mem[lk_ch];

  assert_save_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (save_en && !save_dflt) |=> mem[$past(save_ch)] == $past(save_data));
  assert_dflt_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
    save_dflt |=> (dflt_q == $past(save_data)) && (mem[$past(save_ch)] == $past(mem[save_ch])));
endmodule

// File: rtl/active_reg.sv
module active_reg
  import freq_sel_pkg::*;
#(
  parameter int unsigned FREQ_W = 32,
  parameter logic [FREQ_W-1:0] DEFAULT_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic [FREQ_W-1:0] lk_word,
  input  logic              direct_en,
  input  logic [FREQ_W-1:0] direct_data,
  output logic [FREQ_W-1:0] active_q,
  output logic              changed_q
);
  load_src_e         src;
  logic [FREQ_W-1:0] next_word;
  logic              load;

  function automatic logic differs(input logic [FREQ_W-1:0] a, input logic [FREQ_W-1:0] b);
    return a != b;
  endfunction

  always_comb begin
    src       = pick_src(fall, direct_en);
    load      = (src != SRC_NONE);
    next_word = (src == SRC_STROBE) ? lk_word : direct_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= DEFAULT_WORD;
      changed_q <= 1'b0;
    end else begin
      changed_q <= load && differs(next_word, active_q);
      if (load) active_q <= next_word;
    end
  end

  assert_strobe_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> active_q == $past(lk_word));
  assert_direct_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_en && !fall) |=> active_q == $past(direct_data));
  assert_pulse_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q != $past(active_q)) |-> changed_q);
  assert_pulse_only_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    changed_q |-> (active_q != $past(active_q)));
endmodule

// File: rtl/preset_selector.sv
module preset_selector #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned FREQ_W = 32,
  parameter logic [FREQ_W-1:0] DEFAULT_WORD = 32'd10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_strobe_n,
  input  logic [IDX_W-1:0]  sel_ch,
  input  logic              save_en,
  input  logic              save_dflt,
  input  logic [IDX_W-1:0]  save_ch,
  input  logic [FREQ_W-1:0] save_data,
  input  logic              direct_en,
  input  logic [FREQ_W-1:0] direct_data,
  input  logic              rd_dflt,
  input  logic [IDX_W-1:0]  rd_ch,
  output logic [FREQ_W-1:0] rd_data,
  output logic [FREQ_W-1:0] active_freq,
  output logic              freq_changed
);
  logic              strobe_fall;
  logic [IDX_W-1:0]  synced_ch;
  logic [FREQ_W-1:0] chan_word;

  strobe_sync #(.IDX_W(IDX_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(sel_strobe_n), .idx_in(sel_ch),
    .fall(strobe_fall), .idx_out(synced_ch)
  );

  preset_table #(.IDX_W(IDX_W), .FREQ_W(FREQ_W), .DEFAULT_WORD(DEFAULT_WORD)) u_tab (
    .clk(clk), .rst_n(rst_n), .save_en(save_en), .save_dflt(save_dflt),
    .save_ch(save_ch), .save_data(save_data), .lk_ch(synced_ch), .lk_word(chan_word),
    .rd_dflt(rd_dflt), .rd_ch(rd_ch), .rd_data(rd_data)
  );

  active_reg #(.FREQ_W(FREQ_W), .DEFAULT_WORD(DEFAULT_WORD)) u_act (
    .clk(clk), .rst_n(rst_n), .fall(strobe_fall), .lk_word(chan_word),
    .direct_en(direct_en), .direct_data(direct_data),
    .active_q(active_freq), .changed_q(freq_changed)
  );

  assert_stable_no_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_fall && !direct_en) |=> $stable(active_freq));
endmodule

// File: tb/sim_preset_selector.sv
module sim_preset_selector;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DEF = 32'd10_000_000;

  typedef struct packed {
    logic [1:0]  op;   // 0 save, 1 strobe, 2 direct
    logic [5:0]  ch;
    logic [31:0] val;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{2'd0, 6'd0,  32'd123_000_000},
    '{2'd0, 6'd63, 32'd123_456_000},
    '{2'd0, 6'd5,  32'd1_000_000},
    '{2'd1, 6'd0,  32'd0},
    '{2'd1, 6'd63, 32'd0},
    '{2'd2, 6'd0,  32'd850_000_000},
    '{2'd1, 6'd5,  32'd0},
    '{2'd0, 6'd5,  32'd77},
    '{2'd1, 6'd5,  32'd0},
    '{2'd2, 6'd0,  32'd77},
    '{2'd1, 6'd9,  32'd0}
  };

  logic clk = 0, rst_n = 0;
  logic sel_strobe_n = 1;
  logic [5:0] sel_ch = 0, save_ch = 0, rd_ch = 0;
  logic save_en = 0, save_dflt = 0, direct_en = 0, rd_dflt = 0;
  logic [31:0] save_data = 0, direct_data = 0;
  logic [31:0] rd_data, active_freq;
  logic freq_changed;

  int compared = 0, mismatched = 0;
  logic [31:0] model [64];
  logic [31:0] m_act;

  always #(CLK_PERIOD/2) clk = ~clk;

  preset_selector #(.DEFAULT_WORD(DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_strobe_n(sel_strobe_n), .sel_ch(sel_ch),
    .save_en(save_en), .save_dflt(save_dflt), .save_ch(save_ch), .save_data(save_data),
    .direct_en(direct_en), .direct_data(direct_data), .rd_dflt(rd_dflt), .rd_ch(rd_ch),
    .rd_data(rd_data), .active_freq(active_freq), .freq_changed(freq_changed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_save(input logic dflt, input logic [5:0] c, input logic [31:0] v);
    @(negedge clk);
    save_en = !dflt; save_dflt = dflt; save_ch = c; save_data = v;
    @(negedge clk);
    save_en = 0; save_dflt = 0;
    if (!dflt) model[c] = v;
  endtask

  task automatic do_read(input string req, input logic dflt, input logic [5:0] c, input logic [31:0] exp);
    @(negedge clk);
    rd_dflt = dflt; rd_ch = c;
    @(negedge clk);
    chk(req, rd_data, exp);
  endtask

  task automatic do_strobe(input logic [5:0] c);
    logic [31:0] old;
    old = m_act;
    @(negedge clk);
    sel_ch = c; sel_strobe_n = 0;
    repeat (2) @(negedge clk);
    chk("R3 early", active_freq, old);
    @(negedge clk);
    m_act = model[c];
    chk("R3", active_freq, m_act);
    chk("R8 pulse", {31'd0, freq_changed}, {31'd0, m_act != old});
    @(negedge clk);
    chk("R8 width", {31'd0, freq_changed}, 32'd0);
    sel_strobe_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_direct(input logic [31:0] v);
    logic [31:0] old;
    old = m_act;
    @(negedge clk);
    direct_en = 1; direct_data = v;
    @(negedge clk);
    direct_en = 0;
    m_act = v;
    chk("R6", active_freq, m_act);
    chk("R8 pulse", {31'd0, freq_changed}, {31'd0, m_act != old});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 0;
    m_act = DEF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 active", active_freq, DEF);
    chk("R1 pulse", {31'd0, freq_changed}, 32'd0);
    do_read("R1 default", 1, 0, DEF);
    do_read("R1 table", 0, 17, 0);

    for (int k = 0; k < 11; k++) begin
      case (VECS[k].op)
        2'd0: begin
          do_save(0, VECS[k].ch, VECS[k].val);
          chk("R2 no active change", active_freq, m_act);
          do_read("R2", 0, VECS[k].ch, model[VECS[k].ch]);
        end
        2'd1: do_strobe(VECS[k].ch);
        default: do_direct(VECS[k].val);
      endcase
    end

    // R9: read several channels
    do_read("R9", 0, 0, model[0]);
    do_read("R9", 0, 63, model[63]);

    // R4: hold strobe low, change index, then release
    do_save(0, 20, 32'd444);
    do_strobe(0);
    @(negedge clk);
    sel_ch = 0; sel_strobe_n = 0;
    repeat (4) @(negedge clk);
    sel_ch = 20;
    repeat (6) @(negedge clk);
    chk("R4 held low", active_freq, model[0]);
    sel_strobe_n = 1;
    repeat (6) @(negedge clk);
    chk("R4 rising", active_freq, model[0]);
    m_act = model[0];

    // R5: default slot write
    do_save(1, 20, 32'd5_555);
    chk("R5 active", active_freq, m_act);
    do_read("R5 default", 1, 0, 32'd5_555);
    do_read("R5 table", 0, 20, 32'd444);

    // R7: direct in the same cycle the fall is acted on
    @(negedge clk);
    sel_ch = 20; sel_strobe_n = 0;
    repeat (2) @(negedge clk);
    direct_en = 1; direct_data = 32'd999;
    @(negedge clk);
    direct_en = 0;
    chk("R7", active_freq, 32'd444);
    chk("R7 pulse", {31'd0, freq_changed}, 32'd1);
    sel_strobe_n = 1;
    repeat (3) @(negedge clk);

    // R1 again: reset restores parameter default
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 re-reset", active_freq, DEF);
    do_read("R1 re-reset default", 1, 0, DEF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule